// File: doc/BRIEF.md
# Subcarrier Manchester frame transmitter

This block sends the answer frames of a proximity card at 106 kbit/s by load modulation. A frame is a start bit, then the data bytes least significant bit first, each byte followed by an odd parity bit, and finally one unmodulated half-bit that closes the frame. Each bit is two half-bits, and the modulated half carries a subcarrier of one sixteenth of the carrier. The output `lm_out` is that subcarrier gated by the modulation enable, and it drives the load switch directly. CRC bytes are not computed here. They arrive as ordinary data.

A controller asserts `start` together with the byte count and the number of cycles that must pass before the answer may begin. The block then pulls exactly that many bytes through a valid/ready byte port, one byte ahead of the one being sent. The block raises `busy` for the whole frame and pulses `done` when the frame ends.

The system clock need not be an integer multiple of the bit rate. A half-bit lasts `HALF_CYC` cycles. A build parameter can then stretch or shrink every `ADJ_EVERY`-th half-bit by one cycle, so that the average half-bit period matches a non-integer clock ratio.

Top module: `subc_manchester_tx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy`, `done`, `mod_en`, `lm_out` and `in_ready` are all 0.
- R2: `start` is taken only when `busy` is 0 and `frame_len` is not 0. A `start` while a frame is running, or with `frame_len` = 0, has no effect on the outputs. A `start` in the cycle in which `done` is 1 is taken.
- R3: After the clock edge that takes `start`, `mod_en` stays 0 for `resp_delay` further cycles. The start bit begins exactly `resp_delay`+1 cycles after the taking edge, and never earlier.
- R4: The start bit is modulated in its first half and unmodulated in its second half.
- R5: A data bit of value 1 is modulated in its first half and unmodulated in its second half. A data bit of value 0 is the reverse. The bits of each byte are sent least significant bit first, and the bytes are sent in the order they were received.
- R6: After the 8 data bits of each byte, a parity bit is sent with the same half-bit coding as a data bit. Its value makes the number of ones across the data and parity bits odd, and it is computed afresh for every byte.
- R7: After the last parity bit, one unmodulated half-bit closes the frame. In the cycle after that half-bit, `done` is 1 for exactly one cycle.
- R8: Half-bits are numbered from 1, starting at the first half of the start bit and including the closing half-bit. A half-bit lasts `HALF_CYC` cycles. With `ADJ_MODE` = 2, every half-bit whose number is a multiple of `ADJ_EVERY` lasts `HALF_CYC`+1 cycles. With `ADJ_MODE` = 1, those half-bits last `HALF_CYC`-1 cycles. With `ADJ_MODE` = 0, no half-bit is adjusted.
- R9: `lm_out` is `mod_en` AND a subcarrier that toggles every `SUB_HALF` cycles. The subcarrier phase restarts high on the first cycle of the start bit.
- R10: `in_ready` is 1 only while `busy` is 1. Exactly `frame_len` bytes are accepted per frame, through `in_valid` and `in_ready` both being 1 at a clock edge.
- R11: `busy` is 1 from the cycle after the taking edge until the closing half-bit ends. It falls in the same cycle in which `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to send a frame |
| frame_len | input | LEN_W | Number of bytes in the frame, sampled with `start` |
| resp_delay | input | DLY_W | Cycles to wait before the start bit, sampled with `start` |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | The block takes the offered byte at this edge |
| busy | output | 1 | A frame is pending or being sent |
| done | output | 1 | One-cycle pulse at the end of a frame |
| mod_en | output | 1 | Load-modulation enable, the Manchester half-bit level |
| lm_out | output | 1 | Load-modulation drive: `mod_en` gated with the subcarrier |

## Verification
Two situations can fall in the same cycle. In the first, the end of one frame (`done`) coincides with the acceptance of the next `start`. The bench provokes this by holding `start` high through the tail of a frame, so that each of the two instances, one lengthening and one shortening half-bits, takes the new frame exactly in its own `done` cycle. The bench judges the result against a per-cycle reference that begins the new frame's delay count on that very edge. In the second situation, a length-adjusted half-bit can land on a byte boundary, that is, on a parity half or on the load of the next byte. Frames of several lengths and response delays move the adjustment across these boundaries. Every cycle's busy, done, modulation and gated output is compared against the reference.

// File: rtl/smtx_pkg.sv
package smtx_pkg;
  localparam int ADJ_NONE  = 0;
  localparam int ADJ_SHORT = 1;
  localparam int ADJ_LONG  = 2;
  localparam int BYTE_W    = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SEND
  } tx_state_e;

  typedef enum logic [1:0] {
    PH_SOF,
    PH_DATA,
    PH_EOF
  } tx_phase_e;
endpackage

// File: rtl/smtx_halfbit_timer.sv
module smtx_halfbit_timer
  import smtx_pkg::*;
#(
  parameter int HALF_CYC  = 64,
  parameter int ADJ_MODE  = ADJ_NONE,
  parameter int ADJ_EVERY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic half_end
);
  localparam int CNT_W = $clog2(HALF_CYC + 2);
  localparam int IDX_W = $clog2(ADJ_EVERY + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADJ_EVERY - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_plain;
  logic [CNT_W-1:0] len_adj;
  logic [CNT_W-1:0] len_first;
  logic [CNT_W-1:0] len_next;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_nx;

  // load values are length minus one
  assign len_plain = CNT_W'(HALF_CYC - 1);

  generate
    if (ADJ_MODE == ADJ_LONG) begin : g_long
      assign len_adj = CNT_W'(HALF_CYC);
    end else if (ADJ_MODE == ADJ_SHORT) begin : g_short
      assign len_adj = CNT_W'(HALF_CYC - 2);
    end else begin : g_plain
      assign len_adj = CNT_W'(HALF_CYC - 1);
    end
  endgenerate

  assign idx_nx    = (idx == LAST_IDX) ? '0 : idx + 1'b1;
  assign len_next  = (idx_nx == LAST_IDX) ? len_adj : len_plain;
  assign len_first = (LAST_IDX == '0) ? len_adj : len_plain;
  assign half_end  = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      idx <= '0;
    end else if (restart) begin
      cnt <= len_first;
      idx <= '0;
    end else if (run) begin
      if (cnt == '0) begin
        cnt <= len_next;
        idx <= idx_nx;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/smtx_subcarrier.sv
module smtx_subcarrier #(
  parameter int SUB_HALF = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic subc
);
  localparam int SC_W = $clog2(SUB_HALF + 1);
  localparam logic [SC_W-1:0] RELOAD = SC_W'(SUB_HALF - 1);

  logic [SC_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= RELOAD;
      subc <= 1'b0;
    end else if (restart) begin
      cnt  <= RELOAD;
      subc <= 1'b1;
    end else if (cnt == '0) begin
      cnt  <= RELOAD;
      subc <= ~subc;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/smtx_framer.sv
module smtx_framer
  import smtx_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int DLY_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [DLY_W-1:0]  resp_delay,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic              half_end,
  output logic              run,
  output logic              restart,
  output logic              mod_en,
  output logic              busy,
  output logic              done
);
  tx_state_e         st;
  tx_phase_e         ph;
  logic [DLY_W-1:0]  dly;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  fetched;
  logic [LEN_W-1:0]  loaded;
  logic [BYTE_W-1:0] hold;
  logic              hold_full;
  logic [BYTE_W-1:0] shreg;
  logic [3:0]        bitpos;
  logic              par;
  logic              second;
  logic              cur_bit;
  logic              take;

  assign in_ready = (st != ST_IDLE) && !hold_full && (fetched != len_q);
  assign take     = in_valid && in_ready;
  assign restart  = (st == ST_WAIT) && (dly == '0);
  assign run      = (st == ST_SEND);

  always_comb begin
    case (ph)
      PH_SOF:  cur_bit = 1'b1;
      PH_DATA: cur_bit = (bitpos == 4'd8) ? ~par : shreg[0];
      default: cur_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ph        <= PH_SOF;
      dly       <= '0;
      len_q     <= '0;
      fetched   <= '0;
      loaded    <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
      shreg     <= '0;
      bitpos    <= '0;
      par       <= 1'b0;
      second    <= 1'b0;
      mod_en    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start && (frame_len != '0)) begin
            st        <= ST_WAIT;
            busy      <= 1'b1;
            len_q     <= frame_len;
            dly       <= resp_delay;
            fetched   <= '0;
            loaded    <= '0;
            hold_full <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (dly == '0) begin
            st     <= ST_SEND;
            ph     <= PH_SOF;
            second <= 1'b0;
            mod_en <= 1'b1;
          end else begin
            dly <= dly - 1'b1;
          end
        end
        default: begin
          if (half_end) begin
            if (!second && (ph != PH_EOF)) begin
              second <= 1'b1;
              mod_en <= ~cur_bit;
            end else begin
              case (ph)
                PH_SOF: begin
                  shreg     <= hold;
                  hold_full <= 1'b0;
                  loaded    <= loaded + 1'b1;
                  bitpos    <= '0;
                  par       <= 1'b0;
                  ph        <= PH_DATA;
                  second    <= 1'b0;
                  mod_en    <= hold[0];
                end
                PH_DATA: begin
                  second <= 1'b0;
                  if (bitpos == 4'd8) begin
                    if (loaded == len_q) begin
                      ph     <= PH_EOF;
                      mod_en <= 1'b0;
                    end else begin
                      shreg     <= hold;
                      hold_full <= 1'b0;
                      loaded    <= loaded + 1'b1;
                      bitpos    <= '0;
                      par       <= 1'b0;
                      mod_en    <= hold[0];
                    end
                  end else begin
                    par    <= par ^ shreg[0];
                    shreg  <= shreg >> 1;
                    bitpos <= bitpos + 1'b1;
                    mod_en <= (bitpos == 4'd7) ? ~(par ^ shreg[0]) : shreg[1];
                  end
                end
                default: begin
                  st     <= ST_IDLE;
                  busy   <= 1'b0;
                  done   <= 1'b1;
                  mod_en <= 1'b0;
                end
              endcase
            end
          end
        end
      endcase
      if (take) begin
        hold      <= in_data;
        hold_full <= 1'b1;
        fetched   <= fetched + 1'b1;
      end
    end
  end
endmodule

// File: rtl/subc_manchester_tx.sv
module subc_manchester_tx
  import smtx_pkg::*;
#(
  parameter int HALF_CYC  = 64,
  parameter int SUB_HALF  = 8,
  parameter int ADJ_MODE  = ADJ_NONE,
  parameter int ADJ_EVERY = 8,
  parameter int LEN_W     = 6,
  parameter int DLY_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [DLY_W-1:0]  resp_delay,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              busy,
  output logic              done,
  output logic              mod_en,
  output logic              lm_out
);
  logic half_end;
  logic run;
  logic restart;
  logic subc;

  smtx_framer #(
    .LEN_W (LEN_W),
    .DLY_W (DLY_W)
  ) u_framer (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .frame_len  (frame_len),
    .resp_delay (resp_delay),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .half_end   (half_end),
    .run        (run),
    .restart    (restart),
    .mod_en     (mod_en),
    .busy       (busy),
    .done       (done)
  );

  smtx_halfbit_timer #(
    .HALF_CYC  (HALF_CYC),
    .ADJ_MODE  (ADJ_MODE),
    .ADJ_EVERY (ADJ_EVERY)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .run      (run),
    .half_end (half_end)
  );

  smtx_subcarrier #(
    .SUB_HALF (SUB_HALF)
  ) u_subc (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .subc    (subc)
  );

  assign lm_out = mod_en & subc;
endmodule

// File: rtl/smtx_checker.sv
module smtx_checker #(
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [LEN_W-1:0] frame_len,
  input logic             in_ready,
  input logic             busy,
  input logic             done,
  input logic             mod_en,
  input logic             lm_out
);
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_busy_fall_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_mod_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mod_en);

  p_lm_gate_r9: assert property (@(posedge clk) disable iff (rst)
    lm_out |-> mod_en);

  p_ready_busy_r10: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> busy);

  p_take_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && (frame_len != '0)) |=> busy);

  p_zero_len_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && (frame_len == '0)) |=> !busy);
endmodule

bind subc_manchester_tx smtx_checker #(
  .LEN_W (LEN_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .frame_len (frame_len),
  .in_ready  (in_ready),
  .busy      (busy),
  .done      (done),
  .mod_en    (mod_en),
  .lm_out    (lm_out)
);

// File: tb/tb_subc_manchester_tx.sv
module tb_subc_manchester_tx;
  localparam int HALF  = 6;
  localparam int SUBH  = 2;
  localparam int EV_L  = 7;
  localparam int EV_S  = 8;
  localparam int LEN_W = 4;
  localparam int DLY_W = 4;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [LEN_W-1:0] flen = '0;
  logic [DLY_W-1:0] fdly = '0;
  logic [7:0] din0, din1;
  logic rdy0, rdy1, busy0, busy1, done0, done1, mod0, mod1, lm0, lm1;

  always #10 clk = ~clk;

  logic [7:0] nf  [16];
  logic [7:0] fb0 [16];
  logic [7:0] fb1 [16];
  int nlen = 0, ndly = 0;
  int fidx0 = 0, fidx1 = 0, base0 = 0, base1 = 0, elen0 = 0, elen1 = 0;
  int checks = 0, errors = 0, cyc = 0;
  logic [3:0] eq0 [$];
  logic [3:0] eq1 [$];
  int tg0 [$];
  int tg1 [$];

  assign din0 = fb0[(fidx0 - base0) % 16];
  assign din1 = fb1[(fidx1 - base1) % 16];

  always @(posedge clk) begin
    if (rdy0) fidx0 <= fidx0 + 1;
    if (rdy1) fidx1 <= fidx1 + 1;
  end

  // lengthening instance
  subc_manchester_tx #(
    .HALF_CYC (HALF), .SUB_HALF (SUBH), .ADJ_MODE (2), .ADJ_EVERY (EV_L),
    .LEN_W (LEN_W), .DLY_W (DLY_W)
  ) dut (
    .clk (clk), .rst (rst), .start (start), .frame_len (flen), .resp_delay (fdly),
    .in_valid (1'b1), .in_data (din0), .in_ready (rdy0), .busy (busy0),
    .done (done0), .mod_en (mod0), .lm_out (lm0)
  );

  // shortening instance
  subc_manchester_tx #(
    .HALF_CYC (HALF), .SUB_HALF (SUBH), .ADJ_MODE (1), .ADJ_EVERY (EV_S),
    .LEN_W (LEN_W), .DLY_W (DLY_W)
  ) dut2 (
    .clk (clk), .rst (rst), .start (start), .frame_len (flen), .resp_delay (fdly),
    .in_valid (1'b1), .in_data (din1), .in_ready (rdy1), .busy (busy1),
    .done (done1), .mod_en (mod1), .lm_out (lm1)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic push(input int k, input logic [3:0] v, input int tg);
    if (k == 0) begin eq0.push_back(v); tg0.push_back(tg); end
    else begin eq1.push_back(v); tg1.push_back(tg); end
  endtask

  // Reference frame for instance k, starting at the accepting edge.
  // Entry bits: {busy, done, mod_en, lm_out}; tag = requirement number.
  task automatic build(input int k);
    bit hm [$];
    int ht [$];
    int t, len, dlt, ev, ones;
    bit v, p, sc;
    hm.push_back(1'b1); ht.push_back(4);  // R4 start bit
    hm.push_back(1'b0); ht.push_back(4);
    for (int b = 0; b < nlen; b++) begin
      ones = 0;
      for (int i = 0; i < 8; i++) begin  // R5 LSB first
        v = nf[b][i];
        ones += int'(v);
        hm.push_back(v);  ht.push_back(5);
        hm.push_back(!v); ht.push_back(5);
      end
      p = ((ones % 2) == 0);              // R6 odd parity
      hm.push_back(p);  ht.push_back(6);
      hm.push_back(!p); ht.push_back(6);
    end
    hm.push_back(1'b0); ht.push_back(7);  // R7 closing half
    dlt = (k == 0) ? 1 : -1;
    ev  = (k == 0) ? EV_L : EV_S;
    push(k, 4'b1000, 11);
    for (int d = 0; d < ndly; d++) push(k, 4'b1000, 3);  // R3
    t = 0;
    for (int h = 0; h < hm.size(); h++) begin
      len = HALF + ((((h + 1) % ev) == 0) ? dlt : 0);    // R8
      for (int c = 0; c < len; c++) begin
        sc = (((t / SUBH) % 2) == 0);                    // R9
        push(k, {1'b1, 1'b0, hm[h], hm[h] & sc}, (len != HALF) ? 8 : ht[h]);
        t++;
      end
    end
    push(k, 4'b0100, 7);
    for (int i = 0; i < 16; i++) begin
      if (k == 0) fb0[i] = nf[i]; else fb1[i] = nf[i];
    end
    if (k == 0) begin base0 = fidx0; elen0 = nlen; end
    else begin base1 = fidx1; elen1 = nlen; end
  endtask

  task automatic tick();
    logic [3:0] e, a;
    int tg, got, want;
    @(negedge clk);
    cyc++;
    if (cyc > LIMIT) begin
      errors++;
      $display("FAIL R11 watchdog: actual %0d cycles, expected at most %0d", cyc, LIMIT);
      summary();
    end
    for (int k = 0; k < 2; k++) begin
      tg = rst ? 1 : 2;
      e  = 4'b0000;
      if (k == 0) begin
        a = {busy0, done0, mod0, lm0};
        if (eq0.size() > 0) begin e = eq0.pop_front(); tg = tg0.pop_front(); end
      end else begin
        a = {busy1, done1, mod1, lm1};
        if (eq1.size() > 0) begin e = eq1.pop_front(); tg = tg1.pop_front(); end
      end
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL R%0d inst%0d cycle %0d {busy,done,mod,lm}: actual %b expected %b",
                 tg, k, cyc, a, e);
      end
      if (e[2]) begin  // R10 byte count at end of frame
        got  = (k == 0) ? fidx0 - base0 : fidx1 - base1;
        want = (k == 0) ? elen0 : elen1;
        checks++;
        if (got != want) begin
          errors++;
          $display("FAIL R10 inst%0d bytes taken: actual %0d expected %0d", k, got, want);
        end
      end
    end
  endtask

  // Holds start until each instance has taken the staged frame; an
  // instance still busy ignores it (R2) and takes it in its done cycle.
  task automatic run_frame();
    bit acc0, acc1;
    acc0 = 1'b0;
    acc1 = 1'b0;
    flen  = LEN_W'(nlen);
    fdly  = DLY_W'(ndly);
    start = 1'b1;
    do begin
      if (!acc0 && eq0.size() == 0) begin build(0); acc0 = 1'b1; end
      if (!acc1 && eq1.size() == 0) begin build(1); acc1 = 1'b1; end
      tick();
    end while (!(acc0 && acc1));
    start = 1'b0;
  endtask

  task automatic drain();
    while (eq0.size() > 0 || eq1.size() > 0) tick();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin nf[i] = 8'h00; fb0[i] = 8'h00; fb1[i] = 8'h00; end
    // R1 reset state
    repeat (4) tick();
    rst = 1'b0;
    tick();
    checks++;
    if ({rdy0, rdy1} !== 2'b00) begin
      errors++;
      $display("FAIL R1 in_ready after reset: actual %b expected 00", {rdy0, rdy1});
    end
    repeat (3) tick();

    // frame A: mixed bits, delay 3 (R3 R4 R5 R6 R7)
    nf[0] = 8'hA5; nf[1] = 8'h00; nlen = 2; ndly = 3;
    run_frame();
    drain();
    repeat (2) tick();

    // R2: zero-length start ignored
    flen = '0; fdly = 4'd1; start = 1'b1;
    repeat (3) tick();
    start = 1'b0;
    repeat (2) tick();

    // frame B: four bytes, no delay; start while busy is ignored (R2)
    nf[0] = 8'hFF; nf[1] = 8'h01; nf[2] = 8'h80; nf[3] = 8'h3C; nlen = 4; ndly = 0;
    run_frame();
    repeat (60) tick();
    flen = 4'd1; fdly = 4'd0; start = 1'b1;
    repeat (5) tick();
    start = 1'b0;

    // frame C taken in the done cycle of B (R2 R11), even-weight byte (R6)
    nf[0] = 8'h5A; nlen = 1; ndly = 2;
    run_frame();

    // frame D back to back after C, adjustment crossing byte edges (R8)
    nf[0] = 8'h01; nf[1] = 8'hFE; nf[2] = 8'h7F; nlen = 3; ndly = 5;
    run_frame();
    drain();
    repeat (5) tick();
    summary();
  end
endmodule